// File: doc/BRIEF.md
# Register Bank Serial Slave

This block is a serial-peripheral slave that gives an external master read and write access to a small bank of registers held inside it. Every transfer begins with a command byte. That byte says whether the transfer reads or writes, and it gives the first register address. The data bytes that follow are stored into consecutive registers, or are shifted out from consecutive registers. The address steps up after every byte and wraps back to zero after the top of the bank.

The serial inputs are sampled with the system clock. A synchronizer chain feeds an edge detector, so the serial clock must run several times slower than `clk`. Select is active high. Dropping it at any point ends the transfer. Each stored byte also raises a one-cycle write strobe, so logic next to the block can see the update. The bank contents are brought out as one flat parallel bus.

Top module: `spi_reg_slave`

## Requirements
- R1: A command byte with bit 4 set and bit 7 clear is a write command, and its bits 3:0 are the start address. Each complete byte that follows is stored into the addressed register. Bits 6:5 of the command byte have no effect.
- R2: A command byte with both bit 4 and bit 7 set is a read command, and its bits 3:0 are the start address. The following bytes return register contents on `miso`, most significant bit first, in SPI mode 0. Each bit is valid before the rising `sclk` edge that samples it.
- R3: A transfer with several data bytes touches consecutive addresses, starting at the start address. This holds for both reads and writes.
- R4: Auto-increment wraps from address 0x0F to 0x00.
- R5: A command byte with bit 4 clear is ignored. No register changes for the rest of that transfer, and `miso_oe` stays low until select drops.
- R6: Select is active high. Deasserting it at any point aborts the transfer and discards any partial byte. The next assertion starts again with a command byte.
- R7: Every stored byte produces exactly one single-cycle `wr_stb` pulse, with the target address on `wr_addr` and the byte on `wr_data`.
- R8: After reset all registers read zero, and `miso_oe` and `wr_stb` are low.
- R9: `miso_oe` is high only during the data phase of a read transfer, while select is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs | input | 1 | Slave select, active high |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | High when `miso` should be driven onto the bus |
| wr_stb | output | 1 | One-cycle pulse for each stored byte |
| wr_addr | output | 4 | Address of the stored byte |
| wr_data | output | 8 | Value of the stored byte |
| bank_q | output | 128 | All registers, entry n in bits 8n+7:8n |

## Verification
The bench writes a distinct value to every address with single-byte transfers, then reads each one back. This separates the address decode from the data path. Bursts that start near the top of the bank and run past it, in both directions, show the increment and the wrap. They also show whether the read prefetch lines up with the address that was just stored. Command bytes without the marker bit, command bytes with the don't-care bits set, and select dropped partway through a command or data byte show that only complete, well-formed bytes ever reach the bank.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

   // Phase of a transfer while select is held
   typedef enum logic [1:0] {
      PH_CMD    = 2'd0,
      PH_WRITE  = 2'd1,
      PH_READ   = 2'd2,
      PH_IGNORE = 2'd3
   } phase_e;

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs,
   input  logic mosi,
   output logic sclk_rise,
   output logic cs_on,
   output logic mosi_s
);

   localparam int NLINES = 3;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("spi_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] stg [SYNC_STAGES];
   logic              sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
         sclk_d <= 1'b0;
      end else begin
         stg[0] <= {cs, sclk, mosi};
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         sclk_d <= stg[SYNC_STAGES-1][1];
      end
   end

   assign cs_on     = stg[SYNC_STAGES-1][2];
   assign mosi_s    = stg[SYNC_STAGES-1][0];
   assign sclk_rise = cs_on & stg[SYNC_STAGES-1][1] & ~sclk_d;

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_on,
   input  logic              rise,
   input  logic              mosi_s,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              tx_bit
);

   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_shifter: DATA_W must be at least 2");
   end

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;

   assign byte_done = rise && (bit_cnt == LAST);
   assign rx_byte   = {rx_sh[DATA_W-2:0], mosi_s};
   assign tx_bit    = tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
      end else if (!cs_on) begin
         bit_cnt <= '0;
         tx_sh   <= '0;
      end else if (rise) begin
         rx_sh   <= rx_byte;
         bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
         tx_sh   <= load ? load_data : {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_on |=> (bit_cnt == '0)); // R6

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_regs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int WR_BIT = 4,
   parameter int RD_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_on,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              load,
   output logic [DATA_W-1:0] load_data,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              read_phase
);

   if (WR_BIT >= DATA_W || RD_BIT >= DATA_W) begin : g_bad_bits
      $error("spi_cmd_ctrl: command flag bits must fit in a byte");
   end
   if (WR_BIT == RD_BIT) begin : g_same_bits
      $error("spi_cmd_ctrl: marker and read bits must differ");
   end
   if (ADDR_W > WR_BIT || ADDR_W > RD_BIT) begin : g_addr_overlap
      $error("spi_cmd_ctrl: address field overlaps command flags");
   end

   phase_e            phase;
   logic [ADDR_W-1:0] addr;
   logic              cmd_valid, cmd_read;
   logic [ADDR_W-1:0] cmd_addr, addr_inc;

   assign cmd_valid = rx_byte[WR_BIT];
   assign cmd_read  = rx_byte[RD_BIT];
   assign cmd_addr  = rx_byte[ADDR_W-1:0];
   assign addr_inc  = ADDR_W'(addr + 1'b1);

   // Prefetch address: start address on the command byte, next one in a read
   assign rd_addr   = (phase == PH_CMD) ? cmd_addr : addr_inc;
   assign load      = byte_done &&
                      (((phase == PH_CMD) && cmd_valid && cmd_read) ||
                       (phase == PH_READ));
   assign load_data = rd_data;
   assign read_phase = (phase == PH_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         addr    <= '0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (!cs_on) begin
            phase <= PH_CMD;
         end else if (byte_done) begin
            unique case (phase)
               PH_CMD: begin
                  addr <= cmd_addr;
                  if (!cmd_valid)    phase <= PH_IGNORE;
                  else if (cmd_read) phase <= PH_READ;
                  else               phase <= PH_WRITE;
               end
               PH_WRITE: begin
                  wr_stb  <= 1'b1;
                  wr_addr <= addr;
                  wr_data <= rx_byte;
                  addr    <= addr_inc;
               end
               PH_READ:   addr <= addr_inc;
               PH_IGNORE: addr <= addr;
               default:   phase <= PH_CMD;
            endcase
         end
      end
   end

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R7

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (phase == PH_WRITE || phase == PH_READ))
      |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R3

   AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGNORE) |-> !wr_stb); // R5

endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            waddr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [ADDR_W-1:0]            raddr,
   output logic [DATA_W-1:0]            rdata,
   output logic [(1<<ADDR_W)*DATA_W-1:0] flat_q
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_depth
      $error("spi_reg_store: ADDR_W must be within 1..8");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 mem[e] <= RESET_VAL;
         else if (we && (waddr == ADDR_W'(e)))       mem[e] <= wdata;
      end
      assign flat_q[e*DATA_W +: DATA_W] = mem[e];
   end

   assign rdata = mem[raddr];

   AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata))); // R1

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int WR_BIT      = 4,
   parameter int RD_BIT      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sclk,
   input  logic                          cs,
   input  logic                          mosi,
   output logic                          miso,
   output logic                          miso_oe,
   output logic                          wr_stb,
   output logic [ADDR_W-1:0]             wr_addr,
   output logic [DATA_W-1:0]             wr_data,
   output logic [(1<<ADDR_W)*DATA_W-1:0] bank_q
);

   logic              sclk_rise, cs_on, mosi_s;
   logic              byte_done, load, tx_bit, read_phase;
   logic [DATA_W-1:0] rx_byte, load_data, rd_data;
   logic [ADDR_W-1:0] rd_addr;

   spi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .mosi(mosi),
      .sclk_rise(sclk_rise), .cs_on(cs_on), .mosi_s(mosi_s)
   );

   spi_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_on(cs_on), .rise(sclk_rise),
      .mosi_s(mosi_s), .load(load), .load_data(load_data),
      .byte_done(byte_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
   );

   spi_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .WR_BIT(WR_BIT), .RD_BIT(RD_BIT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_on(cs_on), .byte_done(byte_done),
      .rx_byte(rx_byte), .rd_data(rd_data), .rd_addr(rd_addr),
      .load(load), .load_data(load_data), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data), .read_phase(read_phase)
   );

   spi_reg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(wr_stb), .waddr(wr_addr),
      .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data), .flat_q(bank_q)
   );

   assign miso_oe = cs_on & read_phase;
   assign miso    = miso_oe ? tx_bit : 1'b0;

   AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> $past(byte_done)); // R9

endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;

   localparam int HALF = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
   logic         miso, miso_oe, wr_stb;
   logic [3:0]   wr_addr;
   logic [7:0]   wr_data;
   logic [127:0] bank_q;

   int errors = 0, checks = 0;
   int stb_cnt = 0;
   logic watch_oe = 1'b0, oe_seen = 1'b0;
   logic [7:0] model [16];
   logic [7:0] tx_buf [32];
   logic [7:0] rx_buf [32];

   always #2.5 clk = ~clk;

   spi_reg_slave u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .bank_q(bank_q)
   );

   always @(negedge clk) begin
      if (wr_stb) stb_cnt++;
      if (watch_oe && miso_oe) oe_seen = 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic half_wait();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = tx[i];
         half_wait();
         sclk = 1'b1;
         rx[i] = miso;
         half_wait();
         sclk = 1'b0;
      end
   endtask

   task automatic sel_on();
      cs = 1'b1;
      half_wait();
   endtask

   task automatic sel_off();
      half_wait();
      cs = 1'b0;
      half_wait();
      half_wait();
   endtask

   task automatic burst(input logic [7:0] cmd, input int n);
      logic [7:0] r;
      sel_on();
      send_bits(cmd, 8, r);
      for (int k = 0; k < n; k++) begin
         send_bits(tx_buf[k], 8, r);
         rx_buf[k] = r;
      end
      sel_off();
   endtask

   task automatic check_bank(input string req);
      for (int a = 0; a < 16; a++) chk(req, bank_q[a*8 +: 8], model[a]);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int s;
      for (int a = 0; a < 16; a++) model[a] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8 reset state
      chk("R8 bank", bank_q, 128'h0);
      chk("R8 miso_oe", miso_oe, 1'b0);
      chk("R8 wr_stb", wr_stb, 1'b0);

      // R1, R7: single writes to every address
      for (int a = 0; a < 16; a++) begin
         tx_buf[0] = 8'((a * 37 + 5) & 8'hFF);
         s = stb_cnt;
         burst(8'h10 | 8'(a), 1);
         model[a] = tx_buf[0];
         chk("R7 one strobe", stb_cnt - s, 1);
      end
      check_bank("R1 single write");

      // R2: single reads from every address
      for (int a = 0; a < 16; a++) begin
         tx_buf[0] = 8'h00;
         burst(8'h90 | 8'(a), 1);
         chk("R2 single read", rx_buf[0], model[a]);
      end

      // R3, R4, R7: burst write that runs past 0x0F
      for (int k = 0; k < 10; k++) tx_buf[k] = 8'((k * 11 + 8'h80) & 8'hFF);
      s = stb_cnt;
      burst(8'h1C, 10);
      for (int k = 0; k < 10; k++) model[(12 + k) % 16] = tx_buf[k];
      chk("R7 burst strobes", stb_cnt - s, 10);
      check_bank("R4 write wrap");

      // R3, R4, R9: burst read wrapping more than once
      for (int k = 0; k < 20; k++) tx_buf[k] = 8'h00;
      watch_oe = 1'b0;
      burst(8'h99, 20);
      for (int k = 0; k < 20; k++) chk("R3 burst read", rx_buf[k], model[(9 + k) % 16]);
      chk("R9 released after read", miso_oe, 1'b0);

      // R5: commands without the marker bit
      tx_buf[0] = 8'hFF; tx_buf[1] = 8'h55;
      oe_seen = 1'b0; watch_oe = 1'b1; s = stb_cnt;
      burst(8'h0A, 2);
      burst(8'h8F, 2);
      watch_oe = 1'b0;
      chk("R5 no strobe", stb_cnt - s, 0);
      chk("R5 no drive", oe_seen, 1'b0);
      check_bank("R5 bank untouched");

      // R1: don't-care bits 6:5 in the command
      tx_buf[0] = 8'h3C;
      burst(8'h73, 1);
      model[3] = 8'h3C;
      chk("R1 dont-care write", bank_q[3*8 +: 8], 8'h3C);
      burst(8'hF3, 1);
      chk("R2 dont-care read", rx_buf[0], 8'h3C);

      // R6: abort during a data byte
      begin
         logic [7:0] r;
         sel_on();
         send_bits(8'h12, 8, r);
         send_bits(8'hAA, 8, r);
         send_bits(8'h77, 4, r);
         sel_off();
         model[2] = 8'hAA;
         check_bank("R6 partial byte dropped");
         // abort during a command byte, then a clean write
         sel_on();
         send_bits(8'h1F, 3, r);
         sel_off();
         tx_buf[0] = 8'h5A;
         burst(8'h15, 1);
         model[5] = 8'h5A;
         check_bank("R6 restart after abort");
      end

      // R9: miso_oe during a read data phase
      begin
         logic [7:0] r;
         sel_on();
         send_bits(8'h94, 8, r);
         chk("R9 oe in read", miso_oe, 1'b1);
         send_bits(8'h00, 8, r);
         chk("R2 read after abort", r, model[4]);
         sel_off();
         chk("R9 oe after cs drop", miso_oe, 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule